// File: doc/BRIEF.md
# Randomised Transmit Backoff Scheduler

This block decides when a queued packet may start onto a shared medium. Each transmit attempt advances a growing load mask, uses the mask to select part of a random word, and turns the result into a wait. The wait is counted in external tick strobes by a fine counter of 7-bit periods nested under a small coarse counter. While the wait runs, the receiver is kept enabled. If a packet arrives from the receiver during the wait, the attempt is given up. When the wait ends, the receiver is turned off and transmission is enabled.

A collision reported during transmission makes the block drop transmit-enable and start a fresh attempt with the larger mask, without a new start strobe. When the mask is already full, the attempt ends with a load-overflow error and nothing is sent. The transmitter ends a successful send with a done strobe.

States:
- `ST_IDLE`: waiting for a start strobe.
- `ST_ATTEMPT`: evaluates the mask.
- `ST_WAIT`: backoff countdown.
- `ST_TX`: transmit enabled.
- `ST_RECOV`: one-cycle output disable after a collision.
- `ST_OVF`: one-cycle overflow report.
- `ST_ABORT`: one-cycle abort report.

Transitions:
- IDLE→ATTEMPT on start.
- ATTEMPT→OVF when the mask MSB is set.
- ATTEMPT→TX when the masked value is zero.
- ATTEMPT→WAIT otherwise.
- WAIT→ABORT on a fine expiry with the packet flag set.
- WAIT→TX on a fine expiry with the coarse count exhausted.
- WAIT→WAIT on a fine expiry with coarse count left; the fine counter reloads.
- TX→RECOV on collision, which has priority over done.
- TX→IDLE on done.
- RECOV→ATTEMPT.
- OVF→IDLE.
- ABORT→IDLE.

Top module: `backoff_sched`

## Requirements
- R1: Reset drives `load_o` to 0 and holds `tx_en_o`, `rx_en_o`, `abort_o` and `load_ovf_o` low.
- R2: Each attempt that does not overflow replaces the load with the old load shifted left by one with bit 0 set. The load changes at no other time.
- R3: If bit 15 of the old load is set, the attempt gives a one-cycle `load_ovf_o` pulse, does not enable transmit, and leaves `load_o` unchanged.
- R4: The masked value is `rnd_i[11:2]` AND the old load bits [9:0]. If it is zero, `tx_en_o` rises on the second clock edge after the start strobe, with no wait phase.
- R5: For a nonzero masked value m, let d = 2·m. Define F = d[6:0] and h = d[8:7]. The wait lasts max(F,1) + 127·max(h−1,0) ticks. `tx_en_o` rises on the edge that accepts the last tick.
- R6: The countdown advances only on clock edges where `tick_i` is high. Cycles without a tick do not shorten the wait.
- R7: If a packet arrived during the wait, the next fine expiry produces a one-cycle `abort_o` pulse instead of transmission, and the block returns to idle.
- R8: The packet-arrived flag is cleared when an attempt is evaluated. A packet reported before the wait starts has no effect.
- R9: `rx_en_o` is high exactly during the wait. `tx_en_o` stays high until `tx_done_i`.
- R10: `coll_i` while transmitting drops `tx_en_o` on the next edge and starts a new attempt with the grown load, without a start strobe.
- R11: `start_i` is ignored outside the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start-attempt strobe |
| rnd_i | input | 16 | Random source word |
| tick_i | input | 1 | Backoff tick strobe |
| pkt_arrived_i | input | 1 | Receiver reports an accepted packet |
| coll_i | input | 1 | Collision seen while transmitting |
| tx_done_i | input | 1 | Transmitter finished the packet |
| tx_en_o | output | 1 | Transmit enable |
| rx_en_o | output | 1 | Receiver enable during the wait |
| abort_o | output | 1 | Attempt aborted (one-cycle pulse) |
| load_ovf_o | output | 1 | Load overflow error (one-cycle pulse) |
| load_o | output | 16 | Current load mask |

## Verification
The hardest situations to reach are the long waits with coarse reloads and the overflow error. Both depend on a load that only grows one bit per attempt from reset. The stimulus therefore runs a fixed sequence of attempts, including one collision-driven retry, so the load climbs step by step. Random words are chosen so the masked value lands on the coarse boundaries: zero fine part, dropped upper bits, and two reloads. A packet pulse is timed to fall inside the second fine period. The sequence then keeps retrying with a zero random word until the load saturates and the next attempt overflows.

// File: rtl/bo_pkg.sv
package bo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ATTEMPT,
        ST_WAIT,
        ST_TX,
        ST_RECOV,
        ST_OVF,
        ST_ABORT
    } bo_state_t;

endpackage

// File: rtl/bo_load_reg.sv
module bo_load_reg #(
    parameter int LOAD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    output logic [LOAD_W-1:0] load_o,
    output logic              msb_o
);

    logic [LOAD_W-1:0] load_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '0;
        end else if (step_i) begin
            load_q <= {load_q[LOAD_W-2:0], 1'b1};
        end
    end

    assign load_o = load_q;
    assign msb_o  = load_q[LOAD_W-1];

    // R2
    load_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> ($countones(load_o) == $countones($past(load_o)) + 1) && load_o[0]);

    // R2
    load_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(load_o));

endmodule

// File: rtl/bo_mask_calc.sv
module bo_mask_calc #(
    parameter int RND_W    = 16,
    parameter int MASK_W   = 10,
    parameter int MASK_LSB = 2,
    parameter int FINE_W   = 7,
    parameter int COARSE_W = 2
) (
    input  logic [RND_W-1:0]    rnd_i,
    input  logic [MASK_W-1:0]   load_lo_i,
    output logic                zero_o,
    output logic [FINE_W-1:0]   fine_o,
    output logic [COARSE_W-1:0] hi_o
);

    localparam int DBL_W = MASK_W + 1;

    logic [MASK_W-1:0] field;
    logic [MASK_W-1:0] masked;
    logic [DBL_W-1:0]  dbl;
    logic              unused_bits;

    assign field  = rnd_i[MASK_LSB +: MASK_W];
    assign masked = field & load_lo_i;
    assign dbl    = {masked, 1'b0};
    assign zero_o = (masked == '0);
    assign fine_o = dbl[FINE_W-1:0];
    assign hi_o   = dbl[FINE_W +: COARSE_W];

    assign unused_bits = ^{rnd_i, dbl};

endmodule

// File: rtl/bo_wait_timer.sv
module bo_wait_timer #(
    parameter int FINE_W   = 7,
    parameter int COARSE_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [FINE_W-1:0]   fine_init_i,
    input  logic [COARSE_W-1:0] hi_i,
    input  logic                run_i,
    input  logic                tick_i,
    output logic                expire_o,
    output logic                final_o
);

    localparam int               CW       = COARSE_W + 1;
    localparam logic [FINE_W-1:0] FINE_MAX = '1;

    logic [FINE_W-1:0] fine_q;
    logic [CW-1:0]     crs_q;

    assign expire_o = run_i && tick_i && (fine_q <= FINE_W'(1));
    assign final_o  = crs_q[CW-1] || (crs_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fine_q <= '0;
            crs_q  <= '0;
        end else if (load_i) begin
            fine_q <= fine_init_i;
            crs_q  <= {1'b0, hi_i} - CW'(1);
        end else if (expire_o && !final_o) begin
            fine_q <= FINE_MAX;
            crs_q  <= crs_q - CW'(1);
        end else if (run_i && tick_i && !expire_o) begin
            fine_q <= fine_q - FINE_W'(1);
        end
    end

    // R6
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i && !load_i) |=> $stable(fine_q));

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !final_o) |=> (fine_q == FINE_MAX));

endmodule

// File: rtl/backoff_sched.sv
module backoff_sched import bo_pkg::*; #(
    parameter int LOAD_W   = 16,
    parameter int RND_W    = 16,
    parameter int MASK_W   = 10,
    parameter int MASK_LSB = 2,
    parameter int FINE_W   = 7,
    parameter int COARSE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [RND_W-1:0]  rnd_i,
    input  logic              tick_i,
    input  logic              pkt_arrived_i,
    input  logic              coll_i,
    input  logic              tx_done_i,
    output logic              tx_en_o,
    output logic              rx_en_o,
    output logic              abort_o,
    output logic              load_ovf_o,
    output logic [LOAD_W-1:0] load_o
);

    bo_state_t state_q, state_d;

    logic                load_msb;
    logic                mask_zero;
    logic                tmr_expire;
    logic                tmr_final;
    logic                pkt_flag_q;
    logic                pkt_seen;
    logic                step;
    logic                tmr_load;
    logic                tmr_run;
    logic [FINE_W-1:0]   fine_init;
    logic [COARSE_W-1:0] hi_init;

    assign step     = (state_q == ST_ATTEMPT) && !load_msb;
    assign tmr_load = step && !mask_zero;
    assign tmr_run  = (state_q == ST_WAIT);
    assign pkt_seen = pkt_flag_q || pkt_arrived_i;

    bo_load_reg #(
        .LOAD_W (LOAD_W)
    ) u_load (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .load_o (load_o),
        .msb_o  (load_msb)
    );

    bo_mask_calc #(
        .RND_W    (RND_W),
        .MASK_W   (MASK_W),
        .MASK_LSB (MASK_LSB),
        .FINE_W   (FINE_W),
        .COARSE_W (COARSE_W)
    ) u_mask (
        .rnd_i     (rnd_i),
        .load_lo_i (load_o[MASK_W-1:0]),
        .zero_o    (mask_zero),
        .fine_o    (fine_init),
        .hi_o      (hi_init)
    );

    bo_wait_timer #(
        .FINE_W   (FINE_W),
        .COARSE_W (COARSE_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (tmr_load),
        .fine_init_i (fine_init),
        .hi_i        (hi_init),
        .run_i       (tmr_run),
        .tick_i      (tick_i),
        .expire_o    (tmr_expire),
        .final_o     (tmr_final)
    );

    // packet-arrived flag: cleared when an attempt is evaluated
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_flag_q <= 1'b0;
        end else if (state_q == ST_ATTEMPT) begin
            pkt_flag_q <= 1'b0;
        end else if (pkt_arrived_i) begin
            pkt_flag_q <= 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_ATTEMPT;
            end
            ST_ATTEMPT: begin
                if (load_msb)       state_d = ST_OVF;
                else if (mask_zero) state_d = ST_TX;
                else                state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (tmr_expire) begin
                    if (pkt_seen)       state_d = ST_ABORT;
                    else if (tmr_final) state_d = ST_TX;
                end
            end
            ST_TX: begin
                if (coll_i)         state_d = ST_RECOV;
                else if (tx_done_i) state_d = ST_IDLE;
            end
            ST_RECOV: state_d = ST_ATTEMPT;
            ST_OVF:   state_d = ST_IDLE;
            ST_ABORT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_en_o    = 1'b0;
        rx_en_o    = 1'b0;
        abort_o    = 1'b0;
        load_ovf_o = 1'b0;
        unique case (state_q)
            ST_WAIT:  rx_en_o    = 1'b1;
            ST_TX:    tx_en_o    = 1'b1;
            ST_OVF:   load_ovf_o = 1'b1;
            ST_ABORT: abort_o    = 1'b1;
            default: ;
        endcase
    end

    // R3
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_ovf_o |-> ($stable(load_o) && !tx_en_o));

    // R7
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> (!tx_en_o && !rx_en_o && !abort_o));

    // R10
    coll_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_o && coll_i) |=> !tx_en_o);

endmodule

// File: tb/sim_backoff_sched.sv
`timescale 1ns/1ps
module sim_backoff_sched;

    logic        clk = 1'b0;
    logic        rst_n, start_i, tick_i, pkt_arrived_i, coll_i, tx_done_i;
    logic [15:0] rnd_i;
    logic        tx_en_o, rx_en_o, abort_o, load_ovf_o;
    logic [15:0] load_o;

    int          checks   = 0;
    int          failures = 0;
    logic [15:0] ld_m;

    always #10 clk = ~clk;

    backoff_sched u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .rnd_i         (rnd_i),
        .tick_i        (tick_i),
        .pkt_arrived_i (pkt_arrived_i),
        .coll_i        (coll_i),
        .tx_done_i     (tx_done_i),
        .tx_en_o       (tx_en_o),
        .rx_en_o       (rx_en_o),
        .abort_o       (abort_o),
        .load_ovf_o    (load_ovf_o),
        .load_o        (load_o)
    );

    // {rnd[15:0], packet tick (0 = none), collision after send}
    localparam int NV = 10;
    localparam logic [26:0] VEC [NV] = '{
        {16'hFFFF, 10'd0,   1'b0},
        {16'h0004, 10'd0,   1'b0},
        {16'h0FFC, 10'd0,   1'b0},
        {16'h0FFC, 10'd2,   1'b0},
        {16'h0008, 10'd0,   1'b1},
        {16'h0FFC, 10'd0,   1'b0},
        {16'h0100, 10'd0,   1'b0},
        {16'h0FFC, 10'd200, 1'b0},
        {16'h0600, 10'd0,   1'b0},
        {16'h0800, 10'd0,   1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // kind: 0 transmit, 1 abort, 2 overflow
    function automatic void model(input logic [15:0] ld, input logic [15:0] rnd, input int pk,
                                  output int kind, output int nt, output bit w,
                                  output logic [15:0] nl);
        logic [9:0]  m;
        logic [10:0] d;
        int fe, h, tt, e;
        kind = 0; nt = 0; w = 1'b0; nl = ld;
        if (ld[15]) begin
            kind = 2;
            return;
        end
        nl = {ld[14:0], 1'b1};
        m  = rnd[11:2] & ld[9:0];
        if (m == 10'd0) return;
        d  = {m, 1'b0};
        fe = int'(d[6:0]);
        if (fe == 0) fe = 1;
        h  = int'(d[8:7]);
        tt = fe + 127 * ((h >= 2) ? h - 1 : 0);
        w  = 1'b1;
        nt = tt;
        if (pk > 0) begin
            e = fe;
            while (e < pk) e += 127;
            if (e <= tt) begin
                kind = 1;
                nt   = e;
            end
        end
    endfunction

    task automatic observe(input int pk, input int gap, input bit poke,
                           output int kind, output int ticks, output int cyc, output bit saw_wait);
        kind = -1; ticks = 0; cyc = 0; saw_wait = 1'b0;
        while (cyc < 3000) begin
            if (tx_en_o)    begin kind = 0; break; end
            if (abort_o)    begin kind = 1; break; end
            if (load_ovf_o) begin kind = 2; break; end
            tick_i = 1'b0; pkt_arrived_i = 1'b0; start_i = 1'b0;
            if (rx_en_o) begin
                saw_wait = 1'b1;
                if (cyc % gap == 0) begin
                    ticks++;
                    tick_i = 1'b1;
                    if (ticks == pk) pkt_arrived_i = 1'b1;
                end
                if (poke && ticks == 2) start_i = 1'b1;
            end
            @(negedge clk);
            cyc++;
        end
        tick_i = 1'b0; pkt_arrived_i = 1'b0; start_i = 1'b0;
    endtask

    task automatic run_one(input logic [15:0] rnd, input int pk, input int gap, input bit poke,
                           input bit fresh, output int kind);
        int ek, et, t, c;
        bit ew, sw;
        logic [15:0] nl;
        string tag;
        model(ld_m, rnd, pk, ek, et, ew, nl);
        observe(pk, gap, poke, kind, t, c, sw);
        tag = (ek == 2) ? "R3" : (ek == 1) ? "R7" : ew ? (gap > 1 ? "R6" : "R5") : "R4";
        if (poke) tag = "R11";
        if (!fresh) tag = "R10";
        check({tag, " outcome"}, kind, ek);
        check({tag, " tick count"}, t, et);
        check("R9 wait phase seen", int'(sw), int'(ew));
        check((ek == 2) ? "R3 load kept" : "R2 load step", int'(load_o), int'(nl));
        if (fresh && ek == 0 && !ew) check("R4 immediate latency", c, 1);
        ld_m = nl;
    endtask

    task automatic attempt(input logic [15:0] rnd, input int pk, input int gap, input bit poke,
                           input bit coll);
        int k;
        rnd_i = rnd;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        run_one(rnd, pk, gap, poke, 1'b1, k);
        if (k == 0 && coll) begin
            coll_i = 1'b1;
            @(negedge clk);
            coll_i = 1'b0;
            check("R10 tx drop", int'(tx_en_o), 0);
            run_one(rnd, 0, 1, 1'b0, 1'b0, k);
        end
        if (k == 0) begin
            repeat (2) @(negedge clk);
            check("R9 tx held", int'(tx_en_o), 1);
            tx_done_i = 1'b1;
            @(negedge clk);
            tx_done_i = 1'b0;
            check("R9 tx released", int'(tx_en_o), 0);
        end else if (k == 1) begin
            @(negedge clk);
            check("R7 abort pulse", int'(abort_o | tx_en_o), 0);
        end else if (k == 2) begin
            @(negedge clk);
            check("R3 ovf pulse", int'(load_ovf_o | tx_en_o), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; tick_i = 1'b0; pkt_arrived_i = 1'b0;
        coll_i = 1'b0; tx_done_i = 1'b0; rnd_i = '0;
        repeat (3) @(negedge clk);
        check("R1 load at reset", int'(load_o), 0);
        check("R1 outputs at reset", int'({tx_en_o, rx_en_o, abort_o, load_ovf_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", int'({tx_en_o, rx_en_o, abort_o, load_ovf_o}), 0);
        ld_m = '0;

        for (int i = 0; i < NV; i++)
            attempt(VEC[i][26:11], int'(VEC[i][10:1]), 1, 1'b0, VEC[i][0]);

        // R6: ticks every third cycle, long wait with two reloads
        attempt(16'h0FFC, 0, 3, 1'b0, 1'b0);

        // R11: start strobe during the wait is ignored
        attempt(16'h000C, 0, 1, 1'b1, 1'b0);

        // R8: packet reported while idle does not abort the next wait
        pkt_arrived_i = 1'b1;
        @(negedge clk);
        pkt_arrived_i = 1'b0;
        @(negedge clk);
        attempt(16'h000C, 0, 1, 1'b0, 1'b0);

        // R3: fill the load, then overflow
        while (ld_m != 16'hFFFF) attempt(16'h0000, 0, 1, 1'b0, 1'b0);
        attempt(16'h0FFC, 0, 1, 1'b0, 1'b0);
        check("R3 load unchanged after overflow", int'(load_o), 16'hFFFF);

        // R1: reset clears the load
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 load cleared by reset", int'(load_o), 0);
        rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule